// File: doc/BRIEF.md
# Segment descriptor access checker

This block answers privilege and permission questions about a segment selector. A request carries a 16-bit selector, one of four operations and the current privilege level. The four operations are read-verify, write-verify, load-access-rights and load-segment-limit. The block works out where the 8-byte descriptor lives in one of two descriptor tables. It reads that descriptor over a simple request/response port, but only when the selector is non-null and the whole descriptor lies inside the chosen table.

It then judges the descriptor's kind, presence, privilege and access rights. It reports the result as a one-cycle completion pulse carrying:
- a zero flag;
- a 32-bit destination value;
- a destination write-enable with byte enables.

A failed check never raises a fault. It only clears the zero flag and leaves the destination untouched.

The selector carries a 13-bit index in bits 15:3, a table indicator in bit 2 and a requested privilege level in bits 1:0. The requested privilege can only weaken access, never strengthen it.

Top module: `seg_access_checker`

## Requirements
- R1: `req_ready` is high only while idle. A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` stays low from then until the cycle that carries `done`.
- R2: A selector whose bits 15:2 are all zero is null. It completes with `zf`=0 and no descriptor read is issued.
- R3: Selector bit 2 picks table 1 (else table 0). The descriptor is read at that table's base plus index×8. If index×8+7 exceeds that table's limit, the request completes with `zf`=0 and no read.
- R4: Descriptor fields used by the block:
  - byte 5 bit 4 is the segment flag (1 = code/data);
  - byte 5 bit 7 is present;
  - byte 5 bits 6:5 are the DPL;
  - byte 5 bits 3:0 are the type.

  A descriptor with the segment flag clear (task state, table or gate) or with present clear fails every operation.
- R5: The privilege check passes only when DPL ≥ the current privilege level and DPL ≥ the selector's bits 1:0.
- R6: Type bit 3 set means code. Read-verify needs a data segment, or a code segment with type bit 1 set. Write-verify needs a data segment with type bit 1 set.
- R7: Read-verify and write-verify never raise `dest_we`, even when `zf`=1.
- R8: A passing load-access-rights writes descriptor bits 63:32 ANDed with 0x00F0FF00, so bits 19:16 of the result read zero.
- R9: A passing load-segment-limit writes the 20-bit limit. The limit is bytes 0–1 plus byte 6 bits 3:0. If the granularity bit (byte 6 bit 7) is set, the limit is shifted left 12 with 0xFFF ORed in; otherwise it is zero-extended.
- R10: A conforming code segment (type bits 3 and 2 set) skips the privilege check for load-access-rights and load-segment-limit. It does not skip it for the verify operations.
- R11: Whenever `zf`=0 at completion, `dest_we`=0 and `dest_be`=0.
- R12: A write uses `dest_be`=4'b1111 when `req_wide`=1, and 4'b0011 (low 16 bits only) when `req_wide`=0.
- R13: `done` is a single-cycle pulse per accepted request. Outside that cycle `zf`, `dest_we` and `dest_be` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_selector | input | 16 | Selector: index 15:3, table bit 2, requested privilege 1:0 |
| req_op | input | 2 | 0 read-verify, 1 write-verify, 2 load-access-rights, 3 load-segment-limit |
| req_cpl | input | 2 | Current privilege level |
| req_wide | input | 1 | 1 = 32-bit destination, 0 = 16-bit |
| tbl0_base | input | AW | Table 0 base address |
| tbl0_limit | input | LW | Table 0 byte limit |
| tbl1_base | input | AW | Table 1 base address |
| tbl1_limit | input | LW | Table 1 byte limit |
| rd_req | output | 1 | One-cycle descriptor read request |
| rd_addr | output | AW | Descriptor address |
| rd_rsp_valid | input | 1 | Descriptor data valid |
| rd_rsp_data | input | 64 | Descriptor, byte 0 in bits 7:0 |
| done | output | 1 | Completion pulse |
| zf | output | 1 | Zero flag: every check passed |
| dest_value | output | DW | Destination value |
| dest_we | output | 1 | Destination write-enable |
| dest_be | output | DW/8 | Destination byte enables |

## Verification
A wrong latched selector or table choice shows at the ports in the cycle `rd_req` rises: the address points at the wrong descriptor. It also shows at `done`, because a null or out-of-limit case either issues a read or fails to issue one.

A wrong verdict in the evaluation logic appears in the single `done` cycle, as a flipped `zf` or a stray `dest_we`. This happens the cycle after the descriptor data returns.

A wrong mask or granularity expansion corrupts `dest_value` only on passing access-rights and segment-limit requests. The scoreboard therefore places descriptors with nonzero limit bits 19:16, both granularity settings and a full 20-bit limit.

A stuck state machine shows first as `req_ready` staying low, and then as `done` never arriving.

// File: rtl/seg_chk_pkg.sv
`timescale 1ns/1ps
package seg_chk_pkg;
  typedef enum logic [1:0] {
    OP_RD_VERIFY     = 2'd0,
    OP_WR_VERIFY     = 2'd1,
    OP_ACCESS_RIGHTS = 2'd2,
    OP_SEG_LIMIT     = 2'd3
  } seg_op_e;

  typedef struct packed {
    logic [31:0] upper;
    logic [19:0] limit;
    logic        gran;
    logic        present;
    logic [1:0]  dpl;
    logic        is_seg;
    logic [3:0]  typ;
  } desc_view_t;

  localparam logic [31:0] RIGHTS_MASK = 32'h00F0_FF00;

  function automatic desc_view_t unpack_desc(input logic [63:0] d);
    desc_view_t v;
    v.upper   = d[63:32];
    v.limit   = {d[51:48], d[15:0]};
    v.gran    = d[55];
    v.present = d[47];
    v.dpl     = d[46:45];
    v.is_seg  = d[44];
    v.typ     = d[43:40];
    return v;
  endfunction
endpackage

// File: rtl/seg_chk_gate.sv
`timescale 1ns/1ps
module seg_chk_gate #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic [12:0]   idx,
  input  logic          ti,
  input  logic [AW-1:0] base0,
  input  logic [LW-1:0] lim0,
  input  logic [AW-1:0] base1,
  input  logic [LW-1:0] lim1,
  output logic          is_null,
  output logic          over_limit,
  output logic [AW-1:0] fetch_addr
);
  localparam int CW = (LW > 16) ? LW : 16;

  logic [15:0]   last_byte;
  logic [CW-1:0] last_ext;
  logic [CW-1:0] lim_ext;

  always_comb begin
    last_byte  = {idx, 3'b111};
    last_ext   = CW'(last_byte);
    lim_ext    = ti ? CW'(lim1) : CW'(lim0);
    is_null    = (idx == 13'd0) && !ti;
    over_limit = last_ext > lim_ext;
    fetch_addr = (ti ? base1 : base0) + AW'({idx, 3'b000});
  end
endmodule

// File: rtl/seg_chk_judge.sv
`timescale 1ns/1ps
module seg_chk_judge #(
  parameter int DW = 32
) (
  input  logic [63:0]     desc,
  input  logic [1:0]      op,
  input  logic [1:0]      cpl,
  input  logic [1:0]      rpl,
  input  logic            wide,
  output logic            pass,
  output logic            write_dest,
  output logic [DW-1:0]   value,
  output logic [DW/8-1:0] be
);
  import seg_chk_pkg::*;
  localparam int BEW = DW / 8;

  desc_view_t v;
  logic is_code, readable, writable, conforming, priv_ok, usable;
  logic [31:0] rights_word, limit_word;
  wire unused_base = ^desc[31:16];

  always_comb begin
    v           = unpack_desc(desc);
    is_code     = v.typ[3];
    readable    = !is_code || v.typ[1];
    writable    = !is_code && v.typ[1];
    conforming  = is_code && v.typ[2];
    priv_ok     = (v.dpl >= cpl) && (v.dpl >= rpl);
    usable      = v.is_seg && v.present;
    unique case (seg_op_e'(op))
      OP_RD_VERIFY: pass = usable && priv_ok && readable;
      OP_WR_VERIFY: pass = usable && priv_ok && writable;
      default:      pass = usable && (priv_ok || conforming);
    endcase
    write_dest  = pass && op[1];
    rights_word = v.upper & RIGHTS_MASK;
    limit_word  = v.gran ? {v.limit, 12'hFFF} : {12'h000, v.limit};
    value       = (seg_op_e'(op) == OP_ACCESS_RIGHTS) ? DW'(rights_word) : DW'(limit_word);
    if (!write_dest)
      be = '0;
    else if (wide)
      be = {BEW{1'b1}};
    else
      be = BEW'({(BEW/2){1'b1}});
  end
endmodule

// File: rtl/seg_access_checker.sv
`timescale 1ns/1ps
module seg_access_checker #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [15:0]     req_selector,
  input  logic [1:0]      req_op,
  input  logic [1:0]      req_cpl,
  input  logic            req_wide,
  input  logic [AW-1:0]   tbl0_base,
  input  logic [LW-1:0]   tbl0_limit,
  input  logic [AW-1:0]   tbl1_base,
  input  logic [LW-1:0]   tbl1_limit,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic            rd_rsp_valid,
  input  logic [63:0]     rd_rsp_data,
  output logic            done,
  output logic            zf,
  output logic [DW-1:0]   dest_value,
  output logic            dest_we,
  output logic [DW/8-1:0] dest_be
);
  localparam int BEW = DW / 8;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_ISSUE, S_WAIT} state_e;
  state_e state;

  logic [15:0]   sel_q;
  logic [1:0]    op_q, cpl_q;
  logic          wide_q;
  logic [AW-1:0] addr_q;

  logic          g_null, g_over;
  logic [AW-1:0] g_addr;
  logic          j_pass, j_write;
  logic [DW-1:0] j_value;
  logic [BEW-1:0] j_be;

  seg_chk_gate #(.AW(AW), .LW(LW)) u_gate (
    .idx(sel_q[15:3]), .ti(sel_q[2]),
    .base0(tbl0_base), .lim0(tbl0_limit),
    .base1(tbl1_base), .lim1(tbl1_limit),
    .is_null(g_null), .over_limit(g_over), .fetch_addr(g_addr)
  );

  seg_chk_judge #(.DW(DW)) u_judge (
    .desc(rd_rsp_data), .op(op_q), .cpl(cpl_q), .rpl(sel_q[1:0]), .wide(wide_q),
    .pass(j_pass), .write_dest(j_write), .value(j_value), .be(j_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      sel_q      <= '0;
      op_q       <= '0;
      cpl_q      <= '0;
      wide_q     <= 1'b0;
      addr_q     <= '0;
      done       <= 1'b0;
      zf         <= 1'b0;
      dest_we    <= 1'b0;
      dest_be    <= '0;
      dest_value <= '0;
    end else begin
      done    <= 1'b0;
      zf      <= 1'b0;
      dest_we <= 1'b0;
      dest_be <= '0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          sel_q  <= req_selector;
          op_q   <= req_op;
          cpl_q  <= req_cpl;
          wide_q <= req_wide;
          state  <= S_CHECK;
        end
        S_CHECK: if (g_null || g_over) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end else begin
          addr_q <= g_addr;
          state  <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (rd_rsp_valid) begin
          done    <= 1'b1;
          zf      <= j_pass;
          dest_we <= j_write;
          dest_be <= j_be;
          if (j_write) dest_value <= j_value;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rd_req    = (state == S_ISSUE);
  assign rd_addr   = addr_q;
endmodule

// File: rtl/seg_access_checker_sva.sv
`timescale 1ns/1ps
module seg_access_checker_sva #(
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_op,
  input logic            rd_req,
  input logic            done,
  input logic            zf,
  input logic [DW-1:0]   dest_value,
  input logic            dest_we,
  input logic [DW/8-1:0] dest_be
);
  logic [1:0] op_seen;

  always_ff @(posedge clk) begin
    if (rst) op_seen <= '0;
    else if (req_valid && req_ready) op_seen <= req_op;
  end

  assert_single_outstanding_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_read_while_busy_R1: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !req_ready);

  assert_verify_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !op_seen[1]) |-> !dest_we);

  assert_rights_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (dest_we && op_seen == 2'd2) |-> (dest_value[19:16] == 4'h0 && dest_value[7:0] == 8'h00));

  assert_fail_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (done && !zf) |-> (!dest_we && dest_be == '0));

  assert_be_shape_R12: assert property (@(posedge clk) disable iff (rst)
    dest_we |-> ($countones(dest_be) == DW/8 || $countones(dest_be) == DW/16));

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_quiet_idle_R13: assert property (@(posedge clk) disable iff (rst)
    !done |-> (!zf && !dest_we));
endmodule

bind seg_access_checker seg_access_checker_sva #(.DW(DW)) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .rd_req(rd_req), .done(done), .zf(zf),
  .dest_value(dest_value), .dest_we(dest_we), .dest_be(dest_be)
);

// File: tb/sim_seg_access_checker.sv
`timescale 1ns/1ps
module sim_seg_access_checker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_selector = '0;
  logic [1:0]  req_op = '0;
  logic [1:0]  req_cpl = '0;
  logic        req_wide = 1'b1;
  logic [31:0] tbl0_base = 32'h0000_1000;
  logic [15:0] tbl0_limit = 16'd127;
  logic [31:0] tbl1_base = 32'h0000_2000;
  logic [15:0] tbl1_limit = 16'd31;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_rsp_valid;
  logic [63:0] rd_rsp_data;
  logic        done, zf, dest_we;
  logic [31:0] dest_value;
  logic [3:0]  dest_be;

  always #2.5 clk = ~clk;

  seg_access_checker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_selector(req_selector), .req_op(req_op), .req_cpl(req_cpl), .req_wide(req_wide),
    .tbl0_base(tbl0_base), .tbl0_limit(tbl0_limit), .tbl1_base(tbl1_base), .tbl1_limit(tbl1_limit),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .done(done), .zf(zf), .dest_value(dest_value), .dest_we(dest_we), .dest_be(dest_be)
  );

  typedef struct {
    logic        zf;
    logic        we;
    logic [3:0]  be;
    logic [31:0] val;
    int          reads;
    int          rd_base;
    string       tag;
  } item_t;

  item_t q[$];
  logic [63:0] t0 [0:15];
  logic [63:0] t1 [0:3];
  int checks = 0;
  int fails = 0;
  int rd_cnt = 0;
  bit finished = 1'b0;

  function automatic logic [63:0] mk(input logic [19:0] lim, input logic [3:0] typ,
                                     input logic s, input logic [1:0] dpl,
                                     input logic p, input logic g);
    return {8'h12, g, 1'b1, 1'b0, 1'b1, lim[19:16], p, dpl, s, typ,
            8'h34, 16'h5678, lim[15:0]};
  endfunction

  function automatic item_t model(input logic [63:0] d, input logic [1:0] op,
                                  input logic [1:0] cpl, input logic [1:0] rpl,
                                  input logic wide, input string tag);
    item_t it;
    logic [3:0] t;
    logic ok_kind, ok_priv, pass;
    t       = d[43:40];
    ok_kind = d[44] && d[47];
    ok_priv = (d[46:45] >= cpl) && (d[46:45] >= rpl);
    case (op)
      2'd0:    pass = ok_kind && ok_priv && (!t[3] || t[1]);
      2'd1:    pass = ok_kind && ok_priv && !t[3] && t[1];
      default: pass = ok_kind && (ok_priv || (t[3] && t[2]));
    endcase
    it.zf  = pass;
    it.we  = pass && op[1];
    it.be  = it.we ? (wide ? 4'hF : 4'h3) : 4'h0;
    if (op == 2'd2) it.val = d[63:32] & 32'h00F0_FF00;
    else if (d[55]) it.val = {d[51:48], d[15:0], 12'hFFF};
    else            it.val = {12'h000, d[51:48], d[15:0]};
    it.reads   = 1;
    it.rd_base = 0;
    it.tag     = tag;
    return it;
  endfunction

  function automatic logic [63:0] mem_at(input logic [31:0] a);
    if (a >= 32'h1000 && a < 32'h1080 && a[2:0] == 3'b000) return t0[a[6:3]];
    if (a >= 32'h2000 && a < 32'h2020 && a[2:0] == 3'b000) return t1[a[4:3]];
    return 64'hDEAD_BEEF_DEAD_BEEF;
  endfunction

  task automatic send(input logic [15:0] sel, input logic [1:0] op, input logic [1:0] cpl,
                      input logic wide, input string tag);
    item_t it;
    logic [15:0] last;
    last = {sel[15:3], 3'b111};
    if (sel[15:2] == 14'd0 || last > (sel[2] ? 16'd31 : 16'd127)) begin
      it.zf = 1'b0; it.we = 1'b0; it.be = 4'h0; it.val = '0;
      it.reads = 0; it.tag = tag;
    end else begin
      it = model(sel[2] ? t1[sel[4:3]] : t0[sel[6:3]], op, cpl, sel[1:0], wide, tag);
    end
    while (req_ready !== 1'b1) @(negedge clk);
    it.rd_base = rd_cnt;
    q.push_back(it);
    req_selector = sel; req_op = op; req_cpl = cpl; req_wide = wide;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (req_ready !== 1'b0) begin
      fails++;
      $display("FAIL R1 %s: req_ready after accept got %b expected 0", tag, req_ready);
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  // descriptor read responder, two-cycle latency
  initial begin
    logic [31:0] ra;
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rd_req === 1'b1) begin
        rd_cnt++;
        ra = rd_addr;
        repeat (2) @(negedge clk);
        rd_rsp_data  = mem_at(ra);
        rd_rsp_valid = 1'b1;
        @(negedge clk);
        rd_rsp_valid = 1'b0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      item_t e;
      int nreads;
      @(negedge clk);
      if (!rst && done === 1'b1) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R13: done got 1 expected 0 (no request pending)");
        end else begin
          e = q.pop_front();
          nreads = rd_cnt - e.rd_base;
          if (zf !== e.zf || dest_we !== e.we || dest_be !== e.be ||
              (e.we && dest_value !== e.val) || nreads != e.reads) begin
            fails++;
            $display("FAIL %s: got zf=%b we=%b be=%h val=%h reads=%0d expected zf=%b we=%b be=%h val=%h reads=%0d",
                     e.tag, zf, dest_we, dest_be, dest_value, nreads,
                     e.zf, e.we, e.be, e.val, e.reads);
          end
        end
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || dest_we !== 1'b0 || zf !== 1'b0) begin
          fails++;
          $display("FAIL R13: after done got done=%b zf=%b we=%b expected 0 0 0", done, zf, dest_we);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog: got run still pending expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) t0[i] = mk(20'h00010, 4'b0010, 1'b1, 2'd3, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++)  t1[i] = mk(20'h00020, 4'b0000, 1'b1, 2'd3, 1'b1, 1'b0);
    t0[1]  = mk(20'hABCDE, 4'b0010, 1'b1, 2'd3, 1'b1, 1'b0); // data rw
    t0[2]  = mk(20'h00100, 4'b0000, 1'b1, 2'd3, 1'b1, 1'b0); // data ro
    t0[3]  = mk(20'h00012, 4'b1010, 1'b1, 2'd0, 1'b1, 1'b1); // code readable, gran
    t0[4]  = mk(20'h00200, 4'b1000, 1'b1, 2'd3, 1'b1, 1'b0); // code exec-only
    t0[5]  = mk(20'h00300, 4'b1110, 1'b1, 2'd0, 1'b1, 1'b0); // conforming readable
    t0[6]  = mk(20'h00067, 4'b1001, 1'b0, 2'd3, 1'b1, 1'b0); // system
    t0[7]  = mk(20'h00400, 4'b0010, 1'b1, 2'd3, 1'b0, 1'b0); // not present
    t0[8]  = mk(20'h00500, 4'b0010, 1'b1, 2'd1, 1'b1, 1'b0); // data dpl1
    t0[15] = mk(20'hFFFFF, 4'b0010, 1'b1, 2'd3, 1'b1, 1'b1); // max limit, gran
    t1[0]  = mk(20'h00777, 4'b0000, 1'b1, 2'd3, 1'b1, 1'b0);
    t1[3]  = mk(20'h00345, 4'b0010, 1'b1, 2'd2, 1'b1, 1'b0);

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (req_ready !== 1'b1 || rd_req !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got ready=%b rd_req=%b expected 1 0", req_ready, rd_req);
    end
    checks++;
    if (done !== 1'b0 || zf !== 1'b0 || dest_we !== 1'b0 || dest_be !== 4'h0) begin
      fails++;
      $display("FAIL R13 reset: got done=%b zf=%b we=%b be=%h expected 0 0 0 0", done, zf, dest_we, dest_be);
    end

    send(16'h0008, 2'd0, 2'd0, 1'b1, "R6 R7 read-verify data");
    send(16'h0008, 2'd1, 2'd0, 1'b1, "R6 R7 write-verify data rw");
    send(16'h0010, 2'd1, 2'd0, 1'b1, "R6 write-verify read-only");
    send(16'h0010, 2'd0, 2'd3, 1'b1, "R6 read-verify read-only");
    send(16'h0020, 2'd0, 2'd3, 1'b1, "R6 read-verify exec-only code");
    send(16'h0018, 2'd0, 2'd0, 1'b1, "R6 read-verify readable code");
    send(16'h0018, 2'd0, 2'd1, 1'b1, "R5 cpl above dpl");
    send(16'h0042, 2'd2, 2'd0, 1'b1, "R5 rpl weakens access");
    send(16'h0041, 2'd2, 2'd0, 1'b1, "R5 rpl equal dpl");
    send(16'h000B, 2'd0, 2'd3, 1'b1, "R5 rpl3 on dpl3");
    send(16'h0008, 2'd2, 2'd0, 1'b1, "R8 access rights mask");
    send(16'h0018, 2'd2, 2'd0, 1'b0, "R8 R12 access rights narrow");
    send(16'h0008, 2'd3, 2'd0, 1'b1, "R9 byte limit");
    send(16'h0018, 2'd3, 2'd0, 1'b1, "R9 granular limit");
    send(16'h0078, 2'd3, 2'd2, 1'b1, "R9 full granular limit");
    send(16'h0008, 2'd3, 2'd0, 1'b0, "R12 narrow limit");
    send(16'h0028, 2'd2, 2'd3, 1'b1, "R10 conforming access rights");
    send(16'h0028, 2'd3, 2'd3, 1'b0, "R10 conforming limit");
    send(16'h0028, 2'd0, 2'd3, 1'b1, "R10 conforming read-verify");
    send(16'h0030, 2'd0, 2'd0, 1'b1, "R4 system descriptor verify");
    send(16'h0030, 2'd2, 2'd0, 1'b1, "R4 R11 system descriptor rights");
    send(16'h0038, 2'd3, 2'd0, 1'b1, "R4 R11 not present");
    send(16'h0003, 2'd2, 2'd0, 1'b1, "R2 null selector");
    send(16'h0000, 2'd0, 2'd0, 1'b1, "R2 null selector verify");
    send(16'h0004, 2'd0, 2'd0, 1'b1, "R3 table1 index0 not null");
    send(16'h001C, 2'd3, 2'd0, 1'b1, "R3 table1 last entry");
    send(16'h0024, 2'd3, 2'd0, 1'b1, "R3 table1 past limit");
    send(16'h0080, 2'd0, 2'd0, 1'b1, "R3 table0 past limit");
    send(16'h0042, 2'd3, 2'd0, 1'b1, "R11 privilege fail limit");

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule